// File: doc/BRIEF.md
# Phase-Keyed Power Signature Modulator

This block produces the enable for a power-pattern shift register during the reset phase of the core it is attached to. The enable sequence carries a signature word, and an off-chip detector can recover that word from the supply voltage. The shift activity is switched on and off at one tenth of the clock rate, which puts the carrier away from the clock frequency. Each signature bit selects the phase of that carrier. A 1 gives five shift cycles and then five idle cycles. A 0 gives the inverted phase: five idle cycles and then five shift cycles.

Each signature bit lasts 32 carrier periods, which is 320 clocks. A rotating pattern register fed by the enable therefore returns to its functional alignment at every bit boundary. The word is sent least significant bit first and repeats for as long as the reset-phase request is held. When the request is dropped, the block finishes the current bit and only then reports that it is idle, so the core never starts with a misaligned register.

The sequencing is a three-state machine:
- ST_IDLE: counters cleared, outputs quiet.
- ST_EMIT: modulating while the request is held.
- ST_DRAIN: the request has been dropped mid-bit and the bit is being completed.

The transitions are:
- ST_IDLE to ST_EMIT when a request is seen.
- ST_EMIT to ST_DRAIN when the request falls before the last cycle of a bit.
- ST_EMIT to ST_IDLE when the request is low in a bit's last cycle.
- ST_DRAIN to ST_IDLE at the bit end with the request low.
- ST_DRAIN to ST_EMIT at the bit end with the request high again.

Top module: `wm_bpsk_mod`

## Requirements
- R1: While reset is asserted or the block is idle, `busy`, `shift_en` and `bit_strobe` are 0 and `bit_idx` is 0.
- R2: When `hold_req` is sampled high in idle, the next cycle has `busy`=1, `bit_idx`=0 and carrier phase 0.
- R3: Within each 10-cycle carrier period, signature bit value 1 drives `shift_en` high in phases 0 to 4 and low in phases 5 to 9, and value 0 drives the inverse. The bit at index b is `sig_word[b]`.
- R4: Each bit lasts exactly 320 cycles (32 carrier periods), and `bit_strobe` is high only in its last cycle.
- R5: If `hold_req` is high in a bit's last cycle, `bit_idx` then advances by one, and wraps from SIG_W-1 to 0.
- R6: If `hold_req` falls during a bit, that bit runs to its end and `busy` falls in the cycle after its strobe. `busy` never falls at any other time.
- R7: A request after a release starts again at bit 0, phase 0.
- R8: Changes on `sig_word` while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req | input | 1 | Reset-phase request; signature is sent while high |
| sig_word | input | SIG_W | Signature word, sent LSB first |
| shift_en | output | 1 | Enable for the power-pattern shift register |
| bit_strobe | output | 1 | High in the last cycle of every signature bit |
| bit_idx | output | clog2(SIG_W) | Index of the bit being sent |
| busy | output | 1 | High while modulating; low releases the core |

## Verification
The bound checker watches several properties on every cycle:
- outputs stay quiet while idle;
- `shift_en` is constant except at the two half-period boundaries of the carrier;
- the strobe falls exactly every 320 cycles;
- the index steps and wraps after each strobe;
- `busy` falls only right after a strobe.

Only the bench's scenarios show the remaining behaviour: that the phase actually follows each individual signature bit, that a drop in the middle of a bit or in its last cycle is followed by the right completion, and that a fresh request restarts at bit 0. The scoreboard compares every cycle against a sequence computed from the word.

// File: rtl/wm_pkg.sv
package wm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_DRAIN = 2'd2
    } wm_state_e;
endpackage

// File: rtl/wm_mod_ctr.sv
module wm_mod_ctr #(
    parameter int MOD = 10,
    parameter int W   = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         last
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    assign last = (cnt == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wm_seq_fsm.sv
module wm_seq_fsm
    import wm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      bit_end,
    output logic      active,
    output logic      cnt_clr
);
    wm_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_EMIT;
            ST_EMIT:  if (!req) state_d = bit_end ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (bit_end) state_d = req ? ST_EMIT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active  = 1'b0;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
            end
            ST_EMIT, ST_DRAIN: begin
                active  = 1'b1;
                cnt_clr = bit_end && (state_d == ST_IDLE);
            end
            default: cnt_clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/wm_bpsk_mod.sv
module wm_bpsk_mod #(
    parameter int SIG_W           = 8,
    parameter int CARRIER_DIV     = 10,
    parameter int PERIODS_PER_BIT = 32,
    parameter int IDX_W           = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_req,
    input  logic [SIG_W-1:0] sig_word,
    output logic             shift_en,
    output logic             bit_strobe,
    output logic [IDX_W-1:0] bit_idx,
    output logic             busy
);
    localparam int PH_W = (CARRIER_DIV > 1) ? $clog2(CARRIER_DIV) : 1;
    localparam int PR_W = (PERIODS_PER_BIT > 1) ? $clog2(PERIODS_PER_BIT) : 1;
    localparam logic [PH_W-1:0] HALF = PH_W'(CARRIER_DIV / 2);

    logic            active, cnt_clr;
    logic [PH_W-1:0] phase;
    logic [PR_W-1:0] period;
    logic            phase_last, period_last, idx_last;
    logic            bit_end, cur_bit;

    assign bit_end = active && phase_last && period_last;

    wm_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (hold_req),
        .bit_end (bit_end),
        .active  (active),
        .cnt_clr (cnt_clr)
    );

    wm_mod_ctr #(.MOD(CARRIER_DIV), .W(PH_W)) u_phase (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr),
        .inc (active),
        .cnt (phase), .last (phase_last)
    );

    wm_mod_ctr #(.MOD(PERIODS_PER_BIT), .W(PR_W)) u_period (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr),
        .inc (active && phase_last),
        .cnt (period), .last (period_last)
    );

    wm_mod_ctr #(.MOD(SIG_W), .W(IDX_W)) u_index (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr),
        .inc (bit_end),
        .cnt (bit_idx), .last (idx_last)
    );

    assign cur_bit    = sig_word[bit_idx];
    assign shift_en   = active && ((phase < HALF) == cur_bit);
    assign bit_strobe = bit_end;
    assign busy       = active;
endmodule

// File: rtl/wm_bpsk_mod_chk.sv
module wm_bpsk_mod_chk #(
    parameter int SIG_W           = 8,
    parameter int CARRIER_DIV     = 10,
    parameter int PERIODS_PER_BIT = 32,
    parameter int IDX_W           = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold_req,
    input logic             shift_en,
    input logic             bit_strobe,
    input logic [IDX_W-1:0] bit_idx,
    input logic             busy
);
    localparam int BIT_LEN = CARRIER_DIV * PERIODS_PER_BIT;
    localparam int CYC_W   = $clog2(BIT_LEN);
    localparam int PH_W    = (CARRIER_DIV > 1) ? $clog2(CARRIER_DIV) : 1;
    localparam logic [PH_W-1:0]  HALF    = PH_W'(CARRIER_DIV / 2);
    localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(CARRIER_DIV - 1);
    localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(BIT_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(SIG_W - 1);

    logic [CYC_W-1:0] cyc;
    logic [PH_W-1:0]  ph;
    logic [IDX_W-1:0] idx_next;

    assign idx_next = (bit_idx == IDX_TOP) ? '0 : bit_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            cyc <= '0;
            ph  <= '0;
        end else begin
            cyc <= (cyc == CYC_TOP) ? '0 : cyc + 1'b1;
            ph  <= (ph == PH_TOP) ? '0 : ph + 1'b1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!shift_en && !bit_strobe && bit_idx == '0));

    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hold_req) |=> (busy && bit_idx == '0));

    a_r3_half_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ph != '0 && ph != HALF) |-> $stable(shift_en));

    a_r4_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_strobe == (cyc == CYC_TOP)));

    a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && hold_req) |=> (busy && bit_idx == $past(idx_next)));

    a_r6_release_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_strobe));

    a_r6_release_when_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !hold_req) |=> !busy);
endmodule

bind wm_bpsk_mod wm_bpsk_mod_chk #(
    .SIG_W           (SIG_W),
    .CARRIER_DIV     (CARRIER_DIV),
    .PERIODS_PER_BIT (PERIODS_PER_BIT),
    .IDX_W           (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req   (hold_req),
    .shift_en   (shift_en),
    .bit_strobe (bit_strobe),
    .bit_idx    (bit_idx),
    .busy       (busy)
);

// File: tb/sim_wm_bpsk_mod.sv
`timescale 1ns/1ps
module sim_wm_bpsk_mod;
    localparam int SW      = 8;
    localparam int IW      = 3;
    localparam int DIV     = 10;
    localparam int PER     = 32;
    localparam int BIT_LEN = DIV * PER;

    typedef struct {
        logic          busy;
        logic          shift;
        logic          strobe;
        logic [IW-1:0] idx;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_req = 1'b0;
    logic [SW-1:0] sig_word = '0;
    logic          shift_en, bit_strobe, busy;
    logic [IW-1:0] bit_idx;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    item_t exp_q[$];

    always #4 clk = ~clk;

    wm_bpsk_mod #(.SIG_W(SW), .CARRIER_DIV(DIV), .PERIODS_PER_BIT(PER)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (hold_req),
        .sig_word   (sig_word),
        .shift_en   (shift_en),
        .bit_strobe (bit_strobe),
        .bit_idx    (bit_idx),
        .busy       (busy)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {busy,shift,strobe,idx} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic push_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.busy = 1'b0; it.shift = 1'b0; it.strobe = 1'b0; it.idx = '0;
            it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    // Expected sequence: bit b uses sig_word[b mod SW]; 1 = shift in phases 0-4
    task automatic push_bits(input logic [SW-1:0] w, input int nbits, input string first_tag);
        for (int b = 0; b < nbits; b++) begin
            for (int c = 0; c < BIT_LEN; c++) begin
                item_t it;
                it.busy   = 1'b1;
                it.shift  = (((c % DIV) < (DIV / 2)) == w[b % SW]);
                it.strobe = (c == BIT_LEN - 1);
                it.idx    = IW'(b % SW);
                if (b == 0 && c == 0)               it.tag = first_tag;
                else if (c == 0 && (b % SW) == 0)   it.tag = "R5 wrap";
                else if (c == 0)                    it.tag = "R5 step";
                else if (c == BIT_LEN - 1)          it.tag = "R4 strobe";
                else                                it.tag = "R3 carrier";
                exp_q.push_back(it);
            end
        end
        push_idle(1, "R6 release");
        push_idle(9, "R1 idle");
    endtask

    // Assert request, drop it at cycle drop_c of bit (nbits-1)
    task automatic episode(input logic [SW-1:0] w, input int nbits, input int drop_c,
                           input string first_tag);
        @(negedge clk);
        sig_word = w;
        hold_req = 1'b1;
        push_bits(w, nbits, first_tag);
        repeat ((nbits - 1) * BIT_LEN + drop_c + 1) @(negedge clk);
        hold_req = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, {busy, shift_en, bit_strobe, bit_idx},
                      {it.busy, it.shift, it.strobe, it.idx});
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        sig_word = 8'hFF;
        hold_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset", {busy, shift_en, bit_strobe, bit_idx}, 6'b0);
        hold_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {busy, shift_en, bit_strobe, bit_idx}, 6'b0);

        // R2/R3/R4/R5/R6: ten bits (wraps), drop mid-bit at cycle 100 of the last
        episode(8'hB2, 10, 100, "R2 start");

        // R8: sig_word churns while idle, outputs stay quiet
        @(negedge clk);
        push_idle(20, "R8 idle ignore");
        for (int i = 0; i < 20; i++) begin
            sig_word = 8'(i * 37 + 5);
            @(negedge clk);
        end
        while (exp_q.size() > 0) @(negedge clk);

        // R7: restart from bit 0; drop in last cycle of bit 1
        episode(8'h5A, 2, BIT_LEN - 1, "R7 restart");

        // R6: drop after first cycle of a single bit, all-zero/all-one halves
        episode(8'h0F, 1, 0, "R7 restart early drop");
        episode(8'hF0, 1, 200, "R7 restart zero bit");

        done = 1'b1;
        finish_run();
    end
endmodule